// File: doc/BRIEF.md
# Folded Six-Level Wavelet Analysis Engine

This block computes a six-level dyadic wavelet decomposition with a single one-level analysis stage that is used again for every level. The stage splits each incoming sample pair into an even and an odd word, passes each through its own first-order all-pass recursion, and combines the two branch results in a lattice. The half-sum becomes the approximation (low band) and the half-difference becomes the detail (high band). Each clock in which the stage is fed consumes one sample pair, so the throughput is two input samples per cycle.

A sequencer steps through the levels. Level 1 reads the external input sample memory. Levels 2 to 6 read the approximation that the previous level left in a shared scratch memory. Every level writes its approximation back into that scratch memory, at lower addresses than the ones it is still reading. Each level writes its detail words to the detail memory that belongs to that level. Between levels the sequencer pulses a clear that zeroes all recursion state in the shared stage, so each level starts with no history. When level 6 has drained, the scratch memory holds the final approximation. All memories sit outside the block: the block drives read enables, a pair address and one shared write port, and it receives synchronous read data.

The sequencer has five states. Idle waits for start. Run issues one pair read per cycle. Drain lasts two cycles and lets the two-register latency empty. Clear lasts one cycle and resets the stage. Done holds after level 6. The transitions are: Idle or Done to Run on start. Run to Drain after the last pair of the level. Drain to Clear after its second cycle for levels 1 to 5, or Drain to Done after level 6. Clear to Run, with the level advanced by one.

Top module: `wv_fold_analyzer`

## Requirements
- R1: After reset, busy=0, done=0, level=1, and in_rd_en, tmp_rd_en and wr_en are all 0.
- R2: A start in Idle or Done runs the levels 1 to 6 in order, and level reports the current one. Busy stays high from the cycle after start until Done, which is (sum over k of N/2^k) + 2 drain cycles per level + 1 clear cycle per level transition. For N=128 this is 143 cycles.
- R3: Level 1 reads only through in_rd_en and levels 2 to 6 read only through tmp_rd_en. The two enables are never high together. A read at pair address p returns word 2p on the even input and word 2p+1 on the odd input, one cycle after the address.
- R4: Level k issues N/2^k reads at pair addresses 0,1,2,... in ascending order. It produces exactly N/2^k writes at addresses 0,1,2,... in ascending order, and every write address is no greater than the current read pair address.
- R5: The even branch computes yA[n] = floor(3*(e[n]-yA[n-1])/16) + e[n-1]. The odd branch computes yB[n] = floor(11*(o[n]-yB[n-1])/16) + o[n-1]. Both histories are zero at the start of every level.
- R6: approximation = floor((yA+yB)/2) and detail = floor((yA-yB)/2). Each is written two cycles after its pair was addressed.
- R7: Each write puts app_data into the scratch memory and det_data into detail memory det_sel, with det_sel equal to the level number 1..6 that produced it.
- R8: A one-cycle clear lies between consecutive levels, and a start also clears the stage. The first output of each level therefore carries no history from an earlier level or an earlier run.
- R9: A start pulse while busy is ignored, and the run produces the same writes and the same busy length.
- R10: After level 6, done=1, busy=0 and level=6. Scratch addresses 0..N/64-1 hold the final approximation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a six-level run (accepted in Idle or Done) |
| busy | output | 1 | High while the levels are being computed |
| done | output | 1 | High in Done after level 6 |
| level | output | 3 | Current level, 1 to 6 |
| in_rd_en | output | 1 | Read enable of the input sample memory |
| tmp_rd_en | output | 1 | Read enable of the scratch approximation memory |
| rd_addr | output | ADDR_W | Pair address shared by both read ports |
| in_even | input | DATA_W | Input memory word 2p |
| in_odd | input | DATA_W | Input memory word 2p+1 |
| tmp_even | input | DATA_W | Scratch memory word 2p |
| tmp_odd | input | DATA_W | Scratch memory word 2p+1 |
| wr_en | output | 1 | Write strobe for scratch and selected detail memory |
| wr_addr | output | ADDR_W | Word address of the write |
| det_sel | output | 3 | Detail memory select, equal to the producing level |
| app_data | output | DATA_W | Approximation word |
| det_data | output | DATA_W | Detail word |

## Verification
The bench targets the first output of every level. A missing or late clear would show up there as a value that carries the previous level's recursion, or the previous run's recursion on a second start. It also follows the source switch at the level 1 to level 2 boundary. A design that kept reading the input memory would return unrelated data. A design with a wrong pair count at the shortest levels would leave queued writes unconsumed or produce extra writes with a wrong busy length. A start pulse injected mid-run must leave the write stream and cycle count unchanged, and the two-word results of level 6 are compared in memory after Done.

// File: rtl/wv_fold_pkg.sv
`timescale 1ns/1ps
package wv_fold_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_CLEAR,
        ST_DONE
    } seq_state_e;

    localparam int NUM_LEVELS   = 6;
    localparam int DRAIN_CYCLES = 2;
endpackage

// File: rtl/wv_allpass_branch.sv
`timescale 1ns/1ps
// First-order all-pass recursion, coefficient COEF_NUM / 2^COEF_SHIFT.
module wv_allpass_branch #(
    parameter int DATA_W     = 16,
    parameter int ACC_W      = 18,
    parameter int COEF_NUM   = 3,
    parameter int COEF_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] x,
    output logic signed [ACC_W-1:0]  y
);
    localparam int PROD_W = ACC_W + 1 + COEF_SHIFT + 2;
    localparam logic signed [PROD_W-1:0] K = PROD_W'(COEF_NUM);

    logic signed [ACC_W-1:0]  x_ext;
    logic signed [ACC_W-1:0]  x_prev;
    logic signed [ACC_W-1:0]  y_prev;
    logic signed [ACC_W:0]    diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;

    always_comb begin
        x_ext  = ACC_W'(x);
        diff   = (ACC_W+1)'(x_ext) - (ACC_W+1)'(y_prev);
        prod   = PROD_W'(diff) * K;
        scaled = prod >>> COEF_SHIFT;
        y      = ACC_W'(scaled) + x_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_prev <= '0;
            y_prev <= '0;
        end else if (clr) begin
            x_prev <= '0;
            y_prev <= '0;
        end else if (en) begin
            x_prev <= x_ext;
            y_prev <= y;
        end
    end

    // R8: a clear leaves no recursion history behind
    p_clear_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (x_prev == '0 && y_prev == '0));
endmodule

// File: rtl/wv_split_stage.sv
`timescale 1ns/1ps
// One analysis level: two all-pass branches and a registered lattice.
module wv_split_stage #(
    parameter int DATA_W     = 16,
    parameter int ACC_W      = 18,
    parameter int COEF_A     = 3,
    parameter int COEF_B     = 11,
    parameter int COEF_SHIFT = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     in_v,
    input  logic signed [DATA_W-1:0] x_even,
    input  logic signed [DATA_W-1:0] x_odd,
    output logic                     out_v,
    output logic signed [DATA_W-1:0] app,
    output logic signed [DATA_W-1:0] det
);
    logic signed [DATA_W-1:0] xin [2];
    logic signed [ACC_W-1:0]  ybr [2];
    logic signed [ACC_W:0]    sum_w;
    logic signed [ACC_W:0]    dif_w;
    logic signed [DATA_W-1:0] app_d;
    logic signed [DATA_W-1:0] det_d;

    assign xin[0] = x_even;
    assign xin[1] = x_odd;

    for (genvar gi = 0; gi < 2; gi++) begin : g_branch
        wv_allpass_branch #(
            .DATA_W    (DATA_W),
            .ACC_W     (ACC_W),
            .COEF_NUM  ((gi == 0) ? COEF_A : COEF_B),
            .COEF_SHIFT(COEF_SHIFT)
        ) u_br (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (clr),
            .en   (in_v),
            .x    (xin[gi]),
            .y    (ybr[gi])
        );
    end

    always_comb begin
        sum_w = (ACC_W+1)'(ybr[0]) + (ACC_W+1)'(ybr[1]);
        dif_w = (ACC_W+1)'(ybr[0]) - (ACC_W+1)'(ybr[1]);
        app_d = DATA_W'(sum_w >>> 1);
        det_d = DATA_W'(dif_w >>> 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            app   <= '0;
            det   <= '0;
        end else begin
            out_v <= in_v && !clr;
            if (in_v) begin
                app <= app_d;
                det <= det_d;
            end
        end
    end

    // R6: one result per consumed pair, one cycle later
    p_out_follows_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_v && !clr) |=> out_v);
    p_no_spurious_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_v |=> !out_v);
endmodule

// File: rtl/wv_level_seq.sv
`timescale 1ns/1ps
// Level sequencer: shrinking read ranges, write addresses, inter-level clear.
module wv_level_seq
    import wv_fold_pkg::*;
#(
    parameter int N_SAMPLES = 128,
    parameter int ADDR_W    = $clog2(N_SAMPLES / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_fire,
    output logic              busy,
    output logic              done,
    output logic [2:0]        level,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              clr,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int PAIRS0 = N_SAMPLES / 2;
    localparam int CNT_W  = ADDR_W + 1;
    localparam logic [2:0] LAST_LVL = 3'(NUM_LEVELS);

    seq_state_e        state_q, state_d;
    logic [2:0]        level_q, level_d;
    logic [ADDR_W-1:0] cnt_q, cnt_d;
    logic              drain_q, drain_d;
    logic [CNT_W-1:0]  wcnt_q;
    logic [CNT_W-1:0]  pairs;
    logic              start_ok;
    logic              last_pair;

    assign start_ok  = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign pairs     = CNT_W'(PAIRS0) >> (level_q - 3'd1);
    assign last_pair = ({1'b0, cnt_q} == pairs - CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        level_d = level_q;
        cnt_d   = cnt_q;
        drain_d = drain_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    state_d = ST_RUN;
                    level_d = 3'd1;
                    cnt_d   = '0;
                end
            end
            ST_RUN: begin
                if (last_pair) begin
                    state_d = ST_DRAIN;
                    drain_d = 1'b0;
                end else begin
                    cnt_d = cnt_q + ADDR_W'(1);
                end
            end
            ST_DRAIN: begin
                if (drain_q == 1'(DRAIN_CYCLES - 1)) begin
                    state_d = (level_q == LAST_LVL) ? ST_DONE : ST_CLEAR;
                end else begin
                    drain_d = 1'b1;
                end
            end
            ST_CLEAR: begin
                state_d = ST_RUN;
                level_d = level_q + 3'd1;
                cnt_d   = '0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level_q <= 3'd1;
            cnt_q   <= '0;
            drain_q <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            cnt_q   <= cnt_d;
            drain_q <= drain_d;
        end
    end

    // write address counter, restarted by every clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (clr) begin
            wcnt_q <= '0;
        end else if (wr_fire) begin
            wcnt_q <= wcnt_q + CNT_W'(1);
        end
    end

    // outputs
    always_comb begin
        busy  = (state_q == ST_RUN) || (state_q == ST_DRAIN) || (state_q == ST_CLEAR);
        done  = (state_q == ST_DONE);
        rd_en = (state_q == ST_RUN);
        clr   = (state_q == ST_CLEAR) || start_ok;
    end

    assign rd_addr = cnt_q;
    assign wr_addr = wcnt_q[ADDR_W-1:0];
    assign level   = level_q;

    // R2: level stays in 1..6
    p_level_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q >= 3'd1 && level_q <= LAST_LVL));
    // R8: a clear cycle is followed by Run at the next level
    p_clear_to_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CLEAR) |=> (state_q == ST_RUN && level_q == $past(level_q) + 3'd1));
    // R4: each write trails the read pointer
    p_wr_trails_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |-> (wcnt_q <= {1'b0, cnt_q}));
    // R4: a level ends with exactly its pair count written
    p_level_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && drain_q) |=> (wcnt_q == $past(pairs)));
    // R10: Done is reached only at level 6
    p_done_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) |-> (level_q == LAST_LVL));
endmodule

// File: rtl/wv_fold_analyzer.sv
`timescale 1ns/1ps
// Top: folded six-level analysis with source muxing between input and scratch memory.
module wv_fold_analyzer #(
    parameter int N_SAMPLES  = 128,
    parameter int DATA_W     = 16,
    parameter int ACC_W      = DATA_W + 2,
    parameter int COEF_A     = 3,
    parameter int COEF_B     = 11,
    parameter int COEF_SHIFT = 4,
    parameter int ADDR_W     = $clog2(N_SAMPLES / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [2:0]        level,
    output logic              in_rd_en,
    output logic              tmp_rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] in_even,
    input  logic [DATA_W-1:0] in_odd,
    input  logic [DATA_W-1:0] tmp_even,
    input  logic [DATA_W-1:0] tmp_odd,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [2:0]        det_sel,
    output logic [DATA_W-1:0] app_data,
    output logic [DATA_W-1:0] det_data
);
    logic                     rd_en;
    logic                     clr;
    logic                     data_v;
    logic                     from_input;
    logic signed [DATA_W-1:0] sel_even;
    logic signed [DATA_W-1:0] sel_odd;
    logic signed [DATA_W-1:0] app_s;
    logic signed [DATA_W-1:0] det_s;

    wv_level_seq #(
        .N_SAMPLES(N_SAMPLES),
        .ADDR_W   (ADDR_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .wr_fire(wr_en),
        .busy   (busy),
        .done   (done),
        .level  (level),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .clr    (clr),
        .wr_addr(wr_addr)
    );

    assign from_input = (level == 3'd1);
    assign in_rd_en   = rd_en && from_input;
    assign tmp_rd_en  = rd_en && !from_input;

    // synchronous memories return data one cycle after the address
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_v <= 1'b0;
        else        data_v <= rd_en;
    end

    assign sel_even = from_input ? in_even : tmp_even;
    assign sel_odd  = from_input ? in_odd  : tmp_odd;

    wv_split_stage #(
        .DATA_W    (DATA_W),
        .ACC_W     (ACC_W),
        .COEF_A    (COEF_A),
        .COEF_B    (COEF_B),
        .COEF_SHIFT(COEF_SHIFT)
    ) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .in_v  (data_v),
        .x_even(sel_even),
        .x_odd (sel_odd),
        .out_v (wr_en),
        .app   (app_s),
        .det   (det_s)
    );

    assign app_data = app_s;
    assign det_data = det_s;
    assign det_sel  = level;

    // R3: one source per level, input memory only at level 1
    p_one_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_rd_en && tmp_rd_en));
    p_input_level1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_rd_en |-> (level == 3'd1));
    // R7: writes never carry a level outside 1..6
    p_det_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (det_sel >= 3'd1 && det_sel <= 3'd6));
endmodule

// File: tb/wv_fold_analyzer_test.sv
`timescale 1ns/1ps
module wv_fold_analyzer_test;
    localparam int N  = 128;
    localparam int W  = 16;
    localparam int AW = 6;
    localparam int BUSY_EXP = 143;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, in_rd_en, tmp_rd_en, wr_en;
    logic [2:0] level, det_sel;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [W-1:0] in_even = '0, in_odd = '0, tmp_even = '0, tmp_odd = '0;
    logic [W-1:0] app_data, det_data;

    always #2.5 clk = ~clk;

    wv_fold_analyzer #(.N_SAMPLES(N), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .level(level), .in_rd_en(in_rd_en), .tmp_rd_en(tmp_rd_en),
        .rd_addr(rd_addr), .in_even(in_even), .in_odd(in_odd),
        .tmp_even(tmp_even), .tmp_odd(tmp_odd), .wr_en(wr_en),
        .wr_addr(wr_addr), .det_sel(det_sel), .app_data(app_data),
        .det_data(det_data)
    );

    // memory models
    logic [W-1:0] in_mem  [N];
    logic [W-1:0] tmp_mem [N];
    logic [W-1:0] det_mem [6][N/2];

    always @(posedge clk) begin
        if (in_rd_en) begin
            in_even <= in_mem[2*int'(rd_addr)];
            in_odd  <= in_mem[2*int'(rd_addr)+1];
        end
        if (tmp_rd_en) begin
            tmp_even <= tmp_mem[2*int'(rd_addr)];
            tmp_odd  <= tmp_mem[2*int'(rd_addr)+1];
        end
        if (wr_en) begin
            tmp_mem[wr_addr] <= app_data;
            if (det_sel >= 3'd1 && det_sel <= 3'd6)
                det_mem[int'(det_sel)-1][wr_addr] <= det_data;
        end
    end

    int total = 0;
    int bad = 0;
    bit mon_on = 1'b0;
    int eq_lvl[$], eq_addr[$], eq_app[$], eq_det[$];
    int rq_src[$], rq_addr[$];
    int exp_det [6][N/2];
    int exp_final [2];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // driver: golden model from R4..R7, pushes expected reads and writes
    task automatic drive_expect(input int pat);
        int cur[$];
        int nxt[$];
        for (int i = 0; i < N; i++) begin
            int v;
            if (pat == 0) v = ((i * 37) % 200 - 100) * 10;
            else          v = (i < 16) ? ((i % 2) ? -1500 : 1500) : ((i * 13) % 500 - 250);
            in_mem[i] = W'(v);
            tmp_mem[i] = '0;
            cur.push_back(v);
        end
        for (int lvl = 1; lvl <= 6; lvl++) begin
            int xa, ya, xb, yb;
            xa = 0; ya = 0; xb = 0; yb = 0;
            nxt.delete();
            for (int p = 0; p < cur.size() / 2; p++) begin
                int e, o, y_a, y_b, ap, dt;
                e = cur[2*p];
                o = cur[2*p+1];
                y_a = (((e - ya) * 3) >>> 4) + xa;
                y_b = (((o - yb) * 11) >>> 4) + xb;
                xa = e; ya = y_a; xb = o; yb = y_b;
                ap = (y_a + y_b) >>> 1;
                dt = (y_a - y_b) >>> 1;
                rq_src.push_back((lvl == 1) ? 1 : 0);
                rq_addr.push_back(p);
                eq_lvl.push_back(lvl);
                eq_addr.push_back(p);
                eq_app.push_back(ap);
                eq_det.push_back(dt);
                exp_det[lvl-1][p] = dt;
                nxt.push_back(ap);
            end
            cur = nxt;
        end
        exp_final[0] = cur[0];
        exp_final[1] = cur[1];
    endtask

    // monitor: compare writes and reads as they appear
    always @(negedge clk) begin
        if (rst_n && mon_on) begin
            if (wr_en) begin
                if (eq_lvl.size() == 0) begin
                    check(1'b0, "R4", "unexpected write addr", int'(wr_addr), -1);
                end else begin
                    int el, ea, ep, ed;
                    el = eq_lvl.pop_front();
                    ea = eq_addr.pop_front();
                    ep = eq_app.pop_front();
                    ed = eq_det.pop_front();
                    check(int'(det_sel) == el, "R7", "det_sel", int'(det_sel), el);
                    check(int'(level) == el, "R2", "level during write", int'(level), el);
                    check(int'(wr_addr) == ea, "R4", "write address", int'(wr_addr), ea);
                    check(int'($signed(app_data)) == ep, (ea == 0) ? "R8" : "R5",
                          "approximation", int'($signed(app_data)), ep);
                    check(int'($signed(det_data)) == ed, (ea == 0) ? "R8" : "R6",
                          "detail", int'($signed(det_data)), ed);
                end
            end
            if (in_rd_en || tmp_rd_en) begin
                if (rq_src.size() == 0) begin
                    check(1'b0, "R4", "unexpected read addr", int'(rd_addr), -1);
                end else begin
                    int es, ea;
                    es = rq_src.pop_front();
                    ea = rq_addr.pop_front();
                    check(in_rd_en == es[0] && tmp_rd_en == !es[0], "R3",
                          "read source (1=input)", int'(in_rd_en), es);
                    check(int'(rd_addr) == ea, "R4", "read pair address", int'(rd_addr), ea);
                end
            end
        end
    end

    task automatic run_case(input int pat, input bit poke);
        int bcnt;
        drive_expect(pat);
        mon_on = 1'b1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        bcnt = 0;
        while (!done) begin
            if (busy) bcnt++;
            // R9: start while busy must be ignored
            start = (poke && (bcnt == 40 || bcnt == 130)) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        repeat (2) @(negedge clk);
        check(bcnt == BUSY_EXP, poke ? "R9" : "R2", "busy cycles", bcnt, BUSY_EXP);
        check(done && !busy, "R10", "done without busy", int'(done), 1);
        check(level == 3'd6, "R10", "final level", int'(level), 6);
        check(eq_lvl.size() == 0, "R4", "writes left unconsumed", eq_lvl.size(), 0);
        check(rq_src.size() == 0, "R4", "reads left unconsumed", rq_src.size(), 0);
        for (int i = 0; i < 2; i++) begin
            check(int'($signed(tmp_mem[i])) == exp_final[i], "R10", "final approximation",
                  int'($signed(tmp_mem[i])), exp_final[i]);
            check(int'($signed(det_mem[5][i])) == exp_det[5][i], "R7", "level 6 detail memory",
                  int'($signed(det_mem[5][i])), exp_det[5][i]);
        end
        check(int'($signed(det_mem[0][N/2-1])) == exp_det[0][N/2-1], "R7", "level 1 last detail",
              int'($signed(det_mem[0][N/2-1])), exp_det[0][N/2-1]);
        check(int'($signed(det_mem[2][3])) == exp_det[2][3], "R7", "level 3 detail",
              int'($signed(det_mem[2][3])), exp_det[2][3]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done in reset", int'(done), 0);
        check(level == 3'd1, "R1", "level in reset", int'(level), 1);
        check(!wr_en && !in_rd_en && !tmp_rd_en, "R1", "enables in reset",
              int'({wr_en, in_rd_en, tmp_rd_en}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy == 1'b0 && level == 3'd1, "R1", "idle after reset", int'(busy), 0);
        run_case(0, 1'b0);
        run_case(1, 1'b0);   // R8: second start must clear stale history
        run_case(0, 1'b1);   // R9: start pulses mid-run
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R2 run did not reach done actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule